// File: doc/BRIEF.md
# Synchronized PWM Run Controller

This block decides when one PWM stage runs and how fast its waveform counter advances. It produces a run enable and a prescaled clock-enable strobe for the stage's waveform counter. The strobe runs at the full clock rate or at one quarter, one thirty-second or one two-hundred-fifty-sixth of it. A 6-bit control word selects the division, starts and stops the stage, makes it a slave of a master stage, and asks for a stop that waits for the current waveform cycle to finish.

A slave stage follows the run requests of other stages. It starts when the master stage runs. It also starts when the master is itself a slave and a third stage runs, so two or three stages can start on the same clock. A small period counter is built in, advanced by the strobe. It ends a waveform cycle when it wraps, and an external cycle-end pulse can end a cycle as well. This lets the deferred stop be exercised without a full waveform generator. A balance mode bit is passed through for the downstream flank width modulation logic.

Control word fields: bits [1:0] divider select, bit 2 run, bit 3 slave mode, bit 4 finish-cycle, bit 5 balance.

Top module: `pwm_run_ctrl`

## Requirements
- R1: While reset is applied and after its release with an all-zero control word, run_en_o, tick_o, cycle_end_o and cnt_o are all 0.
- R2: The divider select ctrl_i[1:0] sets the strobe spacing while running: code 0 gives a strobe every clock, 1 every 4 clocks, 2 every 32 clocks and 3 every 256 clocks.
- R3: The prescaler is held at zero while the stage is stopped, so the first strobe comes on the N-th clock with run_en_o high, where N is the selected division.
- R4: When run (ctrl_i[2]) is 1, run_en_o is 1 on the next clock, whatever the states of slave mode and the other stages.
- R5: With slave mode (ctrl_i[3]) set, master_run_i high makes run_en_o 1 on the next clock.
- R6: With slave mode set, master_slave_i and third_run_i both high make run_en_o 1 on the next clock.
- R7: With no start condition and finish-cycle (ctrl_i[4]) clear, run_en_o falls on the next clock.
- R8: With no start condition, finish-cycle set and slave mode clear, run_en_o stays 1 until a clock on which cycle_end_o is 1, then falls on the next clock.
- R9: In slave mode finish-cycle has no effect: with no start condition run_en_o falls on the next clock.
- R10: balance_o always equals ctrl_i[5].
- R11: cycle_end_o is 1 only on strobe clocks: when the period counter wraps, or when cycle_end_i is high on that clock. cycle_end_i on a clock without a strobe is ignored.
- R12: cnt_o advances by one on each strobe from 0 to period_i and then returns to 0, which is a wrap. It is 0 once the stage has been stopped for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_i | input | 6 | Control word: divider select, run, slave, finish-cycle, balance |
| master_run_i | input | 1 | Run request of the master stage |
| master_slave_i | input | 1 | Slave-mode bit of the master stage |
| third_run_i | input | 1 | Run request of the third stage |
| cycle_end_i | input | 1 | External cycle-end pulse, used on strobe clocks only |
| period_i | input | PER_W | Last count of the period counter |
| run_en_o | output | 1 | Stage run enable |
| tick_o | output | 1 | Prescaled clock-enable strobe |
| cycle_end_o | output | 1 | Waveform cycle ends on this strobe |
| cnt_o | output | PER_W | Period counter value |
| balance_o | output | 1 | Balance mode for flank width modulation |

## Verification
The hardest state to reach is a deferred stop that ends exactly when the cycle ends. The run bit has to be dropped with finish-cycle set and slave mode clear. The stage then has to be seen holding until a wrap or an external pulse lands on a strobe, and falling one clock later. Stray cycle_end_i pulses between strobes must not end it early. The random phase keeps the periods short and the division mostly at 1 or 4. It sets finish-cycle and pulses cycle_end_i often, so many drains end in each of these ways. A directed drain with a period of 5 and a slave-mode drain cover the two sides of R8 and R9 by construction.

// File: rtl/pwm_run_pkg.sv
package pwm_run_pkg;

  localparam int CTRL_W = 6;

  // Control word layout, MSB first
  typedef struct packed {
    logic       balance;   // [5]
    logic       finish;    // [4]
    logic       slave;     // [3]
    logic       run;       // [2]
    logic [1:0] div_sel;   // [1:0]
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } run_state_e;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV1_LOG2 = 2,
  parameter int DIV2_LOG2 = 5,
  parameter int DIV3_LOG2 = 8,
  localparam int PRE_W    = DIV3_LOG2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic [1:0] div_sel,
  output logic       tick
);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;
  logic [PRE_W-1:0] lim_tab [4];
  logic [PRE_W-1:0] lim;

  // Terminal count for each divider code
  for (genvar g = 0; g < 4; g++) begin : g_lim
    localparam int LOG2 = (g == 0) ? 0 :
                          (g == 1) ? DIV1_LOG2 :
                          (g == 2) ? DIV2_LOG2 : DIV3_LOG2;
    assign lim_tab[g] = PRE_W'((1 << LOG2) - 1);
  end

  always_comb begin
    lim  = lim_tab[div_sel];
    tick = run_en && (cnt_q >= lim);
    if (!run_en) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  input  logic             ext_end,
  output logic [PER_W-1:0] cnt,
  output logic             cycle_end
);

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] cnt_d;
  logic             wrap;

  always_comb begin
    wrap      = tick && (cnt_q >= period);
    cycle_end = tick && (wrap || ext_end);
    cnt_d     = cnt_q;
    if (!run_en) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/pwm_run_fsm.sv
module pwm_run_fsm
  import pwm_run_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctl,
  input  logic  master_run,
  input  logic  master_slave,
  input  logic  third_run,
  input  logic  cycle_end,
  output logic  run_en
);

  run_state_e st_q;
  run_state_e st_d;
  logic       start_req;
  logic       hold_req;

  always_comb begin
    // Own run bit wins; otherwise a slave follows the chain
    start_req = ctl.run | (ctl.slave & (master_run | (master_slave & third_run)));
    // Deferred stop only for a stand-alone stage, until the cycle ends
    hold_req  = ctl.finish & ~ctl.slave & ~cycle_end;
    st_d      = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_req) st_d = ST_RUN;
      end
      ST_RUN, ST_DRAIN: begin
        if (start_req)     st_d = ST_RUN;
        else if (hold_req) st_d = ST_DRAIN;
        else               st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign run_en = (st_q != ST_IDLE);

endmodule

// File: rtl/pwm_run_ctrl.sv
module pwm_run_ctrl
  import pwm_run_pkg::*;
#(
  parameter int PER_W     = 8,
  parameter int DIV1_LOG2 = 2,
  parameter int DIV2_LOG2 = 5,
  parameter int DIV3_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              master_run_i,
  input  logic              master_slave_i,
  input  logic              third_run_i,
  input  logic              cycle_end_i,
  input  logic [PER_W-1:0]  period_i,
  output logic              run_en_o,
  output logic              tick_o,
  output logic              cycle_end_o,
  output logic [PER_W-1:0]  cnt_o,
  output logic              balance_o
);

  ctrl_t ctl;
  logic  rst_sync_n;
  logic  run_en;
  logic  tick;
  logic  cyc_end;

  assign ctl = ctrl_t'(ctrl_i);

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_run_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .ctl          (ctl),
    .master_run   (master_run_i),
    .master_slave (master_slave_i),
    .third_run    (third_run_i),
    .cycle_end    (cyc_end),
    .run_en       (run_en)
  );

  pwm_prescaler #(
    .DIV1_LOG2 (DIV1_LOG2),
    .DIV2_LOG2 (DIV2_LOG2),
    .DIV3_LOG2 (DIV3_LOG2)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run_en  (run_en),
    .div_sel (ctl.div_sel),
    .tick    (tick)
  );

  pwm_period_cnt #(.PER_W(PER_W)) u_per (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run_en    (run_en),
    .tick      (tick),
    .period    (period_i),
    .ext_end   (cycle_end_i),
    .cnt       (cnt_o),
    .cycle_end (cyc_end)
  );

  assign run_en_o    = run_en;
  assign tick_o      = tick;
  assign cycle_end_o = cyc_end;
  assign balance_o   = ctl.balance;

endmodule

// File: rtl/pwm_run_ctrl_chk.sv
module pwm_run_ctrl_chk
  import pwm_run_pkg::*;
#(
  parameter int PER_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              master_run_i,
  input logic              master_slave_i,
  input logic              third_run_i,
  input logic              run_en_o,
  input logic              tick_o,
  input logic              cycle_end_o,
  input logic [PER_W-1:0]  cnt_o
);

  ctrl_t ctl;
  logic  chain_go;
  assign ctl      = ctrl_t'(ctrl_i);
  assign chain_go = ctl.slave && (master_run_i || (master_slave_i && third_run_i));

  // R4
  run_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.run |=> run_en_o);

  // R5
  slave_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.slave && master_run_i) |=> run_en_o);

  // R6
  slave_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.slave && master_slave_i && third_run_i) |=> run_en_o);

  // R7
  quick_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.run && !chain_go && !ctl.finish) |=> !run_en_o);

  // R8
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en_o && ctl.finish && !ctl.slave && !cycle_end_o) |=> run_en_o);

  // R8
  drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.run && !ctl.slave && cycle_end_o) |=> !run_en_o);

  // R9
  slave_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.slave && !ctl.run && !chain_go) |=> !run_en_o);

  // R3
  tick_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> run_en_o);

  // R2
  undivided_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en_o && $past(run_en_o) && ctl.div_sel == 2'd0) |-> tick_o);

  // R11
  end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end_o |-> tick_o);

  // R12
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en_o && $past(!run_en_o)) |-> (cnt_o == '0));

endmodule

bind pwm_run_ctrl pwm_run_ctrl_chk #(.PER_W(PER_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .ctrl_i         (ctrl_i),
  .master_run_i   (master_run_i),
  .master_slave_i (master_slave_i),
  .third_run_i    (third_run_i),
  .run_en_o       (run_en_o),
  .tick_o         (tick_o),
  .cycle_end_o    (cycle_end_o),
  .cnt_o          (cnt_o)
);

// File: tb/pwm_run_ctrl_tb.sv
`timescale 1ns/1ps
module pwm_run_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] ctrl;
  logic       mrun, mslave, trun, cei;
  logic [7:0] period;
  logic       run_en_o, tick_o, cycle_end_o, balance_o;
  logic [7:0] cnt_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pwm_run_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .master_run_i(mrun),
    .master_slave_i(mslave), .third_run_i(trun), .cycle_end_i(cei),
    .period_i(period), .run_en_o(run_en_o), .tick_o(tick_o),
    .cycle_end_o(cycle_end_o), .cnt_o(cnt_o), .balance_o(balance_o)
  );

  // Reference state
  logic       m_run;
  logic [7:0] m_pre, m_pcnt;

  function automatic int div_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 32;
      default: return 256;
    endcase
  endfunction

  function automatic logic e_tick();
    return m_run && (int'(m_pre) >= div_of(ctrl[1:0]) - 1);
  endfunction

  function automatic logic e_wrap();
    return e_tick() && (m_pcnt >= period);
  endfunction

  function automatic logic e_end();
    return e_tick() && (e_wrap() || cei);
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk(input string tag);
    cmp(tag, "run_en",    int'(run_en_o),    int'(m_run));
    cmp(tag, "tick",      int'(tick_o),      int'(e_tick()));
    cmp(tag, "cycle_end", int'(cycle_end_o), int'(e_end()));
    cmp(tag, "cnt",       int'(cnt_o),       int'(m_pcnt));
    cmp("R10", "balance", int'(balance_o),   int'(ctrl[5]));
  endtask

  // Called just after a falling edge with inputs set; returns after the next falling edge
  task automatic step(input string tag);
    logic req, n_run, t, w, ce;
    #1;
    chk(tag);
    @(posedge clk);
    t     = e_tick();
    w     = e_wrap();
    ce    = e_end();
    req   = ctrl[2] | (ctrl[3] & (mrun | (mslave & trun)));
    n_run = req | (m_run & ctrl[4] & ~ctrl[3] & ~ce);
    if (!rst_n) begin
      m_run = 0; m_pre = 0; m_pcnt = 0;
    end else begin
      m_pre  = !m_run ? 8'd0 : (t ? 8'd0 : m_pre + 8'd1);
      m_pcnt = !m_run ? 8'd0 : (t ? (w ? 8'd0 : m_pcnt + 8'd1) : m_pcnt);
      m_run  = n_run;
    end
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    ctrl = 6'd0; mrun = 0; mslave = 0; trun = 0; cei = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 0; idle_inputs(); period = 8'd3;
    m_run = 0; m_pre = 0; m_pcnt = 0;
    @(negedge clk);
    // R1: reset state
    repeat (3) step("R1");
    rst_n = 1;
    repeat (4) step("R1");

    // R2 and R3: first strobe and strobe spacing for every divider code
    for (int s = 0; s < 4; s++) begin
      int n, gap;
      period = 8'd200;
      ctrl = {4'b0001, 2'(s)};
      n = 0;
      for (int k = 0; k < 600; k++) begin
        step("R4");
        if (run_en_o) n++;
        if (tick_o) break;
      end
      cmp("R3", "cycles to first strobe", n, div_of(2'(s)));
      gap = 0;
      for (int k = 0; k < 600; k++) begin
        step("R2");
        gap++;
        if (tick_o) break;
      end
      cmp("R2", "strobe spacing", gap, div_of(2'(s)));
      idle_inputs();
      step("R7");
      step("R7");
      cmp("R7", "run_en after stop", int'(run_en_o), 0);
    end

    // R12: counter wrap with period 2, undivided
    period = 8'd2; ctrl = 6'b000100;
    repeat (10) step("R12");
    // R8: deferred stop with period 5
    period = 8'd5; ctrl = 6'b000100;
    repeat (3) step("R8");
    ctrl = 6'b010000;
    repeat (8) step("R8");
    cmp("R8", "run_en after drained cycle", int'(run_en_o), 0);
    // R11: cycle_end_i between strobes is ignored, on a strobe it ends the cycle
    period = 8'd9; ctrl = 6'b000101;
    repeat (3) step("R11");
    ctrl = 6'b010001;
    for (int k = 0; k < 12; k++) begin
      cei = (k % 4) != 3;
      step("R11");
    end
    cei = 0;
    idle_inputs(); step("R7");
    // R5, R6, R9: slave starts and slave stop ignoring finish-cycle
    ctrl = 6'b011000; mrun = 1;
    repeat (4) step("R5");
    mrun = 0; repeat (2) step("R9");
    cmp("R9", "slave stopped", int'(run_en_o), 0);
    mslave = 1; trun = 1;
    repeat (4) step("R6");
    trun = 0; repeat (2) step("R9");
    // R4: run wins over a quiet master in slave mode
    ctrl = 6'b001100; mslave = 0;
    repeat (3) step("R4");
    cmp("R4", "run bit wins", int'(run_en_o), 1);
    idle_inputs(); repeat (2) step("R7");

    // Random mix
    for (int k = 0; k < 40000; k++) begin
      if (($urandom % 12) == 0) begin
        int r;
        r = $urandom % 8;
        ctrl[1:0] = (r < 5) ? 2'd0 : (r < 7) ? 2'd1 : 2'd2;
        ctrl[2]   = ($urandom % 3) == 0;
        ctrl[3]   = ($urandom % 3) == 0;
        ctrl[4]   = ($urandom % 2) == 0;
        ctrl[5]   = $urandom % 2;
        mrun      = ($urandom % 3) == 0;
        mslave    = $urandom % 2;
        trun      = $urandom % 2;
        period    = 8'($urandom % 6);
      end
      cei = ($urandom % 8) == 0;
      step("R11");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule